// File: doc/BRIEF.md
# Banked Register Context File

This block keeps several complete register contexts in one on-chip memory and shows the CPU one of them at a time. A small context pointer register selects the active bank. Every register access gives only a 4-bit index, and the block forms the physical address by placing the pointer above that index. An interrupt or task switch therefore changes one 3-bit value and copies no registers. Register 15 of each bank is used as that context's stack pointer. Because each bank has its own copy of register 15, every interrupt level runs on its own stack.

The control side has three inputs: an entry strobe that carries a target bank, a return strobe, and a software write to the pointer. On entry, the current pointer is pushed onto a four-entry hardware save stack and the target bank becomes active. On return, the most recent saved pointer is popped back, and the interrupted code sees its registers exactly as it left them. A push while the save stack is full sets a sticky overflow flag. A pop while it is empty sets a sticky underflow flag.

Top module: `banked_ctx_regfile`

## Requirements
- R1: While reset is asserted and after it is released, `cur_ctx` is 0, `save_ovf` and `save_unf` are 0, and the save stack is empty.
- R2: The two read ports return, combinationally, the register at physical address {cur_ctx, index}. A write stores `wr_data` at {cur_ctx, `wr_idx`} on the clock edge.
- R3: When `wr_en` is high and a read index equals `wr_idx` in the same cycle, that read port returns `wr_data` in that cycle.
- R4: A write in one bank leaves the same index in every other bank unchanged.
- R5: `ent_stb` pushes the current pointer and loads `ent_ctx` into `cur_ctx`. The new value appears on the cycle after the strobe. Reads and writes during the strobe cycle still use the old bank.
- R6: `ret_stb` with a non-empty save stack loads the most recently saved pointer on the next cycle. Nested entries unwind in last-in, first-out order.
- R7: `ent_stb` while four pointers are already saved sets `save_ovf`, which stays set until reset. It pushes nothing, and the pointer still switches to `ent_ctx`.
- R8: `ret_stb` with an empty save stack sets `save_unf`, which stays set until reset, and leaves `cur_ctx` unchanged.
- R9: `cpw_en` loads `cpw_data` into `cur_ctx` on the next cycle, but only when neither strobe is active. If it coincides with `ent_stb` or `ret_stb`, the strobe's action takes place and the software write is dropped.
- R10: `sp_data` shows register 15 of the active bank. The value written to register 15 in the same cycle is forwarded to it.
- R11: When `ent_stb` and `ret_stb` are both high, the entry takes place and the return is ignored. The stack keeps the pushed pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rda_idx | input | 4 | Read port A register index |
| rda_data | output | 16 | Read port A data |
| rdb_idx | input | 4 | Read port B register index |
| rdb_data | output | 16 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 16 | Write data |
| sp_data | output | 16 | Register 15 (stack pointer) of the active bank |
| ent_stb | input | 1 | Interrupt entry strobe |
| ent_ctx | input | 3 | Bank to activate on entry |
| ret_stb | input | 1 | Interrupt return strobe |
| cpw_en | input | 1 | Software write to the context pointer |
| cpw_data | input | 3 | Value for the software pointer write |
| cur_ctx | output | 3 | Current context pointer |
| save_ovf | output | 1 | Sticky save-stack overflow flag |
| save_unf | output | 1 | Sticky save-stack underflow flag |

## Verification
A table of writes places data at one index in four different banks and at scattered indices in others, then reads every entry back on both ports. A wrong bank-to-address mapping shows up as a value that leaks between banks or reads back wrong.

Entry sequences are checked in two ways. Strobes are applied with reads and writes in the same cycle, which distinguishes a switch that lands a cycle early from one that lands on time. Nesting four deep and then a fifth level compares last-in, first-out unwinding with a stack that drops or reorders entries.

Collisions are driven on purpose: a software write together with each strobe, and entry together with return. These expose a wrong priority order among the three control inputs.

// File: rtl/cpbank_pkg.sv
package cpbank_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_ENTER  = 2'd1,
    ACT_RETURN = 2'd2,
    ACT_SWSET  = 2'd3
  } ctx_act_e;

  // Priority: entry over return over software write.
  function automatic ctx_act_e pick_act(input logic ent, input logic ret, input logic sw);
    if (ent) return ACT_ENTER;
    if (ret) return ACT_RETURN;
    if (sw)  return ACT_SWSET;
    return ACT_NONE;
  endfunction

endpackage

// File: rtl/cpbank_regmem.sv
module cpbank_regmem #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  parameter int CP_W   = 3,
  parameter int NRD    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CP_W-1:0]            cp_i,
  input  logic [NRD-1:0][IDX_W-1:0]  ra_i,
  output logic [NRD-1:0][DATA_W-1:0] rd_o,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           wa_i,
  input  logic [DATA_W-1:0]          wd_i
);
  localparam int ADDR_W = CP_W + IDX_W;
  localparam int NWORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [NWORDS];

  function automatic logic [ADDR_W-1:0] phys(input logic [CP_W-1:0] cp, input logic [IDX_W-1:0] idx);
    return {cp, idx};
  endfunction

  always_ff @(posedge clk) begin
    if (we_i) mem[phys(cp_i, wa_i)] <= wd_i;
  end

  genvar g;
  generate
    for (g = 0; g < NRD; g++) begin : g_rd
      logic fwd_hit;
      assign fwd_hit = we_i && (wa_i == ra_i[g]);
      assign rd_o[g] = fwd_hit ? wd_i : mem[phys(cp_i, ra_i[g])];
    end
  endgenerate

  // A write is visible on the next cycle if the same address is read again.
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> ((cp_i != $past(cp_i)) || (ra_i[0] != $past(wa_i)) ||
              (we_i && wa_i == ra_i[0]) || (rd_o[0] == $past(wd_i)))); // R2

endmodule

// File: rtl/cpbank_ptrstack.sv
module cpbank_ptrstack #(
  parameter int CP_W  = 3,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [CP_W-1:0] din_i,
  output logic [CP_W-1:0] top_o,
  output logic            empty_o,
  output logic            ovf_o,
  output logic            unf_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CP_W-1:0]  stk [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             push_ok, pop_ok;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty_o;
  assign top_o   = empty_o ? '0 : stk[PTR_W'(cnt - CNT_W'(1))];

  always_ff @(posedge clk) begin
    if (push_ok) stk[PTR_W'(cnt)] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      if (push_ok)     cnt <= cnt + CNT_W'(1);
      else if (pop_ok) cnt <= cnt - CNT_W'(1);
      if (push_i && full)    ovf_o <= 1'b1;
      if (pop_i  && empty_o) unf_o <= 1'b1;
    end
  end

  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_i, pop_i})); // R11
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full) |=> (cnt == $past(cnt)) && ovf_o); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o); // R7
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> unf_o); // R8

endmodule

// File: rtl/cpbank_ctrl.sv
module cpbank_ctrl
  import cpbank_pkg::*;
#(
  parameter int CP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ent_stb_i,
  input  logic [CP_W-1:0] ent_ctx_i,
  input  logic            ret_stb_i,
  input  logic            cpw_en_i,
  input  logic [CP_W-1:0] cpw_data_i,
  input  logic [CP_W-1:0] stk_top_i,
  input  logic            stk_empty_i,
  output logic            push_o,
  output logic            pop_o,
  output logic [CP_W-1:0] cp_o
);
  ctx_act_e        act;
  logic            act_enter, act_return, act_sw;
  logic [CP_W-1:0] cp_nxt;

  assign act        = pick_act(ent_stb_i, ret_stb_i, cpw_en_i);
  assign act_enter  = (act == ACT_ENTER);
  assign act_return = (act == ACT_RETURN);
  assign act_sw     = (act == ACT_SWSET);
  assign push_o     = act_enter;
  assign pop_o      = act_return;

  always_comb begin
    cp_nxt = cp_o;
    case (act)
      ACT_ENTER:  cp_nxt = ent_ctx_i;
      ACT_RETURN: if (!stk_empty_i) cp_nxt = stk_top_i;
      ACT_SWSET:  cp_nxt = cpw_data_i;
      default:    cp_nxt = cp_o;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cp_o <= '0;
    else        cp_o <= cp_nxt;
  end

  AST_CP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ent_stb_i && !ret_stb_i && !cpw_en_i) |=> $stable(cp_o)); // R9
  AST_ENTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ent_stb_i |=> (cp_o == $past(ent_ctx_i))); // R5
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_stb_i && !ent_stb_i && !stk_empty_i) |=> (cp_o == $past(stk_top_i))); // R6
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_stb_i && !ent_stb_i && stk_empty_i) |=> $stable(cp_o)); // R8
  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sw) |=> (cp_o == $past(cpw_data_i))); // R9

endmodule

// File: rtl/banked_ctx_regfile.sv
module banked_ctx_regfile #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  parameter int CP_W   = 3,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rda_idx,
  output logic [DATA_W-1:0] rda_data,
  input  logic [IDX_W-1:0]  rdb_idx,
  output logic [DATA_W-1:0] rdb_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sp_data,
  input  logic              ent_stb,
  input  logic [CP_W-1:0]   ent_ctx,
  input  logic              ret_stb,
  input  logic              cpw_en,
  input  logic [CP_W-1:0]   cpw_data,
  output logic [CP_W-1:0]   cur_ctx,
  output logic              save_ovf,
  output logic              save_unf
);
  localparam int NRD = 3;
  localparam logic [IDX_W-1:0] SP_IDX = '1;

  logic [NRD-1:0][IDX_W-1:0]  ra;
  logic [NRD-1:0][DATA_W-1:0] rd;
  logic                       push, pop, stk_empty;
  logic [CP_W-1:0]            stk_top;

  assign ra       = {SP_IDX, rdb_idx, rda_idx};
  assign rda_data = rd[0];
  assign rdb_data = rd[1];
  assign sp_data  = rd[2];

  cpbank_ctrl #(.CP_W(CP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ent_stb_i(ent_stb), .ent_ctx_i(ent_ctx), .ret_stb_i(ret_stb),
    .cpw_en_i(cpw_en), .cpw_data_i(cpw_data),
    .stk_top_i(stk_top), .stk_empty_i(stk_empty),
    .push_o(push), .pop_o(pop), .cp_o(cur_ctx)
  );

  cpbank_ptrstack #(.CP_W(CP_W), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push_i(push), .pop_i(pop), .din_i(cur_ctx),
    .top_o(stk_top), .empty_o(stk_empty), .ovf_o(save_ovf), .unf_o(save_unf)
  );

  cpbank_regmem #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CP_W(CP_W), .NRD(NRD)) u_mem (
    .clk(clk), .rst_n(rst_n), .cp_i(cur_ctx),
    .ra_i(ra), .rd_o(rd),
    .we_i(wr_en), .wa_i(wr_idx), .wd_i(wr_data)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (!rst_n || (cur_ctx == '0 && !save_ovf && !save_unf))); // R1

endmodule

// File: tb/sim_banked_ctx_regfile.sv
`timescale 1ns/1ps
module sim_banked_ctx_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rda_idx = '0, rdb_idx = '0, wr_idx = '0;
  logic [15:0] rda_data, rdb_data, sp_data, wr_data = '0;
  logic        wr_en = 1'b0, ent_stb = 1'b0, ret_stb = 1'b0, cpw_en = 1'b0;
  logic [2:0]  ent_ctx = '0, cpw_data = '0, cur_ctx;
  logic        save_ovf, save_unf;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  banked_ctx_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rda_idx(rda_idx), .rda_data(rda_data), .rdb_idx(rdb_idx), .rdb_data(rdb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sp_data(sp_data),
    .ent_stb(ent_stb), .ent_ctx(ent_ctx), .ret_stb(ret_stb),
    .cpw_en(cpw_en), .cpw_data(cpw_data),
    .cur_ctx(cur_ctx), .save_ovf(save_ovf), .save_unf(save_unf)
  );

  // {bank[22:20], index[19:16], data[15:0]}
  localparam logic [22:0] VEC [8] = '{
    {3'd0, 4'd1,  16'h1111}, {3'd1, 4'd1, 16'h2222},
    {3'd2, 4'd1,  16'h3333}, {3'd7, 4'd1, 16'h7777},
    {3'd3, 4'd0,  16'h3000}, {3'd4, 4'd14, 16'h4E00},
    {3'd5, 4'd9,  16'h5900}, {3'd6, 4'd3, 16'h6300}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [15:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d; cyc(); wr_en = 1'b0;
  endtask

  task automatic setcp(input logic [2:0] v);
    cpw_en = 1'b1; cpw_data = v; cyc(); cpw_en = 1'b0;
  endtask

  task automatic enter(input logic [2:0] t);
    ent_stb = 1'b1; ent_ctx = t; cyc(); ent_stb = 1'b0;
  endtask

  task automatic leave();
    ret_stb = 1'b1; cyc(); ret_stb = 1'b0;
  endtask

  task automatic rd_a(input logic [3:0] idx, output logic [15:0] v);
    rda_idx = idx; #0.5; v = rda_data;
  endtask

  initial begin
    logic [15:0] v;
    #1;
    chk("R1 reset ctx", {13'd0, cur_ctx}, 16'd0);
    chk("R1 reset flags", {14'd0, save_ovf, save_unf}, 16'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    chk("R1 ctx after release", {13'd0, cur_ctx}, 16'd0);

    // R2/R4: table walk, write pass then read-back pass on both ports
    for (int i = 0; i < 8; i++) begin
      setcp(VEC[i][22:20]); wr(VEC[i][19:16], VEC[i][15:0]);
    end
    for (int i = 0; i < 8; i++) begin
      setcp(VEC[i][22:20]);
      rda_idx = VEC[i][19:16]; rdb_idx = VEC[i][19:16]; #0.5;
      chk("R2 R4 port A bank read", rda_data, VEC[i][15:0]);
      chk("R2 port B bank read", rdb_data, VEC[i][15:0]);
    end

    // R3: same-cycle forwarding
    setcp(3'd0);
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 16'hABCD; rda_idx = 4'd5; rdb_idx = 4'd5; #0.5;
    chk("R3 forward A", rda_data, 16'hABCD);
    chk("R3 forward B", rdb_data, 16'hABCD);
    cyc(); wr_en = 1'b0;
    rd_a(4'd5, v); chk("R2 stored after forward", v, 16'hABCD);

    // R10: stack pointer per bank, with forwarding
    setcp(3'd5); wr(4'd15, 16'h5F00); wr(4'd7, 16'h5757);
    setcp(3'd2); wr(4'd15, 16'h2F00);
    #0.5 chk("R10 sp bank2", sp_data, 16'h2F00);
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 16'h2F02; #0.5;
    chk("R10 sp forward", sp_data, 16'h2F02);
    cyc(); wr_en = 1'b0;

    // R5: strobe cycle still uses old bank
    ent_stb = 1'b1; ent_ctx = 3'd5;
    wr_en = 1'b1; wr_idx = 4'd7; wr_data = 16'h00A7;
    rda_idx = 4'd1; #0.5;
    chk("R5 old bank read in strobe cycle", rda_data, 16'h3333);
    chk("R5 ctx unchanged in strobe cycle", {13'd0, cur_ctx}, 16'd2);
    cyc(); ent_stb = 1'b0; wr_en = 1'b0;
    chk("R5 ctx after entry", {13'd0, cur_ctx}, 16'd5);
    #0.5 chk("R10 sp of handler bank", sp_data, 16'h5F00);
    rd_a(4'd7, v); chk("R5 handler bank untouched by strobe-cycle write", v, 16'h5757);
    leave();
    chk("R6 restore after return", {13'd0, cur_ctx}, 16'd2);
    rd_a(4'd7, v); chk("R5 strobe-cycle write landed in old bank", v, 16'h00A7);
    #0.5 chk("R10 sp restored", sp_data, 16'h2F02);

    // R6: nested entries unwind LIFO
    enter(3'd5); enter(3'd6); enter(3'd1);
    chk("R6 nested top", {13'd0, cur_ctx}, 16'd1);
    leave(); chk("R6 unwind 1", {13'd0, cur_ctx}, 16'd6);
    leave(); chk("R6 unwind 2", {13'd0, cur_ctx}, 16'd5);
    leave(); chk("R6 unwind 3", {13'd0, cur_ctx}, 16'd2);

    // R7: overflow
    enter(3'd3); enter(3'd4); enter(3'd5); enter(3'd6);
    chk("R7 no overflow at four", {15'd0, save_ovf}, 16'd0);
    enter(3'd7);
    chk("R7 overflow flag", {15'd0, save_ovf}, 16'd1);
    chk("R7 ctx still switches", {13'd0, cur_ctx}, 16'd7);
    leave(); chk("R7 no push on overflow", {13'd0, cur_ctx}, 16'd5);
    leave(); leave(); leave();
    chk("R7 unwound to base", {13'd0, cur_ctx}, 16'd2);
    chk("R7 overflow sticky", {15'd0, save_ovf}, 16'd1);

    // R8: underflow
    chk("R8 no underflow yet", {15'd0, save_unf}, 16'd0);
    leave();
    chk("R8 underflow flag", {15'd0, save_unf}, 16'd1);
    chk("R8 ctx unchanged on underflow", {13'd0, cur_ctx}, 16'd2);
    cyc();
    chk("R8 underflow sticky", {15'd0, save_unf}, 16'd1);

    // R9: software write alone and in collisions
    cpw_en = 1'b1; cpw_data = 3'd6; #0.5;
    chk("R9 no change before edge", {13'd0, cur_ctx}, 16'd2);
    cyc(); cpw_en = 1'b0;
    chk("R9 sw write applied", {13'd0, cur_ctx}, 16'd6);
    setcp(3'd2);
    cpw_en = 1'b1; cpw_data = 3'd4; ent_stb = 1'b1; ent_ctx = 3'd6;
    cyc(); cpw_en = 1'b0; ent_stb = 1'b0;
    chk("R9 entry beats sw write", {13'd0, cur_ctx}, 16'd6);
    cpw_en = 1'b1; cpw_data = 3'd3; ret_stb = 1'b1;
    cyc(); cpw_en = 1'b0; ret_stb = 1'b0;
    chk("R9 return beats sw write", {13'd0, cur_ctx}, 16'd2);

    // R11: entry and return together
    ent_stb = 1'b1; ent_ctx = 3'd3; ret_stb = 1'b1;
    cyc(); ent_stb = 1'b0; ret_stb = 1'b0;
    chk("R11 entry wins", {13'd0, cur_ctx}, 16'd3);
    leave();
    chk("R11 pushed pointer kept", {13'd0, cur_ctx}, 16'd2);

    // R1: reset again clears flags and pointer
    #1 rst_n = 1'b0; #1;
    chk("R1 reset clears ctx", {13'd0, cur_ctx}, 16'd0);
    chk("R1 reset clears flags", {14'd0, save_ovf, save_unf}, 16'd0);
    cyc(); rst_n = 1'b1; cyc();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule